// File: doc/BRIEF.md
# Two-Channel Request/Acknowledge DMA Port for Three Data FIFOs

This block lets an outside DMA controller move words between a shared data bus and three internal FIFOs (pixel, code and attribute). It holds `NCH` independent request channels (two by default). Software sets each channel's enable, the FIFO it serves, its direction, single or burst pacing, and the way an acknowledge is qualified. A channel raises its request while its FIFO can take a word (external to FIFO) or supply one (FIFO to external). The controller answers on the acknowledge line, and the word moves on the cycle in which the acknowledge is qualified.

An acknowledge can be qualified in three ways. In strobe mode the normal host access strobe must also be high. In fly-by mode the acknowledge is enough on its own. In dedicated-select mode a chip-select line reserved for that channel must be high. In narrow mode the port moves 16-bit words and forces the upper half to zero. In wide mode it uses all 32 bits. The FIFO storage and the host register bridge lie outside the block.

Each channel runs a four-state machine. `CH_OFF` drives no request. `CH_WAIT` drives no request and waits for the FIFO to be ready. `CH_SINGLE` requests one word. `CH_BURST` requests `BURST_LEN` words.

The transitions are:
- OFF→WAIT when the channel is effectively enabled.
- WAIT→SINGLE or WAIT→BURST when the FIFO is ready, chosen by the pacing bit.
- SINGLE→WAIT on a transferred word.
- BURST→WAIT on the last word of a burst.
- Any state→OFF when the channel is no longer effectively enabled.

Top module: `dma_port`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset release, `dreq`, `fifo_push`, `fifo_pop`, `flow_err`, `cfg_err` and `bus_rdata` are all zero.
- R2: Channel c's 2-bit select field `ch_sel[2c+1:2c]` picks its FIFO: 0 pixel, 1 code, 2 attribute. FIFO index f is bit f of `fifo_push`, `fifo_pop`, `fifo_full` and `fifo_empty`, and bits `[32f+31:32f]` of `fifo_rdata`. Select code 3 keeps the channel in `CH_OFF`.
- R3: Single pacing (`ch_burst[c]`=0) works as follows. Once enabled with its FIFO ready, a channel raises `dreq[c]` two clocks after the enable is sampled. After each transferred word `dreq[c]` drops for one cycle. It rises again on the next cycle only if the FIFO is still ready.
- R4: In burst pacing (`ch_burst[c]`=1), `dreq[c]` stays high until `BURST_LEN` (4) words have moved, then drops for at least one cycle.
- R5: With `ch_dir[c]`=1, a transfer pulses the selected FIFO's push bit and never pushes into a full FIFO. With `ch_dir[c]`=0, a transfer pulses the pop bit, never pops an empty FIFO, and presents the popped word on `bus_rdata` in the same cycle.
- R6: Channel c's 2-bit qualifier field `ch_qual[2c+1:2c]` works as follows. Code 0 needs `stb` together with `dack[c]`. Code 1 (fly-by) needs `dack[c]` alone. Code 2 needs `dcs[c]` together with `dack[c]`. Code 3 never qualifies a transfer.
- R7: When two enabled channels with a valid select name the same FIFO, `cfg_err` is high in that cycle. The higher-numbered channel goes to `CH_OFF` and keeps `dreq` low on every following cycle while the clash lasts.
- R8: A qualified acknowledge while `dreq[c]` is high but the FIFO is full (push) or empty (pop) moves no word. It leaves the request asserted and sets `flow_err[c]`, which stays set until reset.
- R9: With `wide`=1, `fifo_wdata` equals `bus_wdata` and popped words pass whole. With `wide`=0, bits 31:16 of both `fifo_wdata` and `bus_rdata` are zero.
- R10: An acknowledge while the channel's `dreq` is low has no effect. At most one word moves per cycle: when several channels qualify together, the lowest-numbered one moves its word and the others' acknowledges are ignored that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Per-channel enable |
| ch_sel | input | 2*NCH | Per-channel FIFO select (0 pixel, 1 code, 2 attribute, 3 none) |
| ch_dir | input | NCH | 1: external to FIFO, 0: FIFO to external |
| ch_burst | input | NCH | 1: burst pacing, 0: single pacing |
| ch_qual | input | 2*NCH | Acknowledge qualifier code per channel |
| wide | input | 1 | 1: 32-bit words, 0: 16-bit words |
| dack | input | NCH | Acknowledge from the DMA controller |
| stb | input | 1 | Normal host access strobe |
| dcs | input | NCH | Dedicated chip select per channel |
| bus_wdata | input | 32 | Data from the external bus |
| bus_rdata | output | 32 | Popped word toward the external bus, zero when none |
| dreq | output | NCH | Request to the DMA controller |
| fifo_full | input | 3 | Full flags of the three FIFOs |
| fifo_empty | input | 3 | Empty flags of the three FIFOs |
| fifo_rdata | input | 96 | Head words of the three FIFOs |
| fifo_push | output | 3 | Write strobe per FIFO |
| fifo_pop | output | 3 | Read strobe per FIFO |
| fifo_wdata | output | 32 | Word written into the selected FIFO |
| cfg_err | output | 1 | Two channels assigned to one FIFO |
| flow_err | output | NCH | Sticky acknowledge-on-full/empty flag per channel |

## Verification
The bench builds the port with its defaults: two channels, three FIFOs, 32-bit words and a burst length of 4. Two channels are the smallest count at which a FIFO clash and two simultaneous acknowledges can occur. A burst of four is short enough that many complete bursts, and bursts cut off by a disable, fit in a short run. Directed phases walk through each qualifier code, both directions, both widths, clashes and flow errors. A long phase then varies every input each cycle, with configuration changes every 40 cycles, so that full, empty and disable events land in every channel state.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_WAIT   = 2'd1,
        CH_SINGLE = 2'd2,
        CH_BURST  = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        QUAL_STROBE = 2'd0,
        QUAL_FLYBY  = 2'd1,
        QUAL_DCS    = 2'd2,
        QUAL_NONE   = 2'd3
    } qual_e;

endpackage

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_port_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic burst,
    input  logic ready,
    input  logic hit,
    output logic dreq,
    output logic xfer,
    output logic flow_err
);
    localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

    ch_state_e state, nxt;
    logic [CW-1:0] beat;
    logic err_set;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= nxt;
    end

    // beat counter and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat     <= '0;
            flow_err <= 1'b0;
        end else begin
            if (state == CH_WAIT)               beat <= '0;
            else if (state == CH_BURST && xfer) beat <= beat + 1'b1;
            if (err_set) flow_err <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        dreq    = (state == CH_SINGLE) || (state == CH_BURST);
        xfer    = dreq && hit && ready;
        err_set = dreq && hit && !ready;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            CH_OFF:    nxt = CH_WAIT;
            CH_WAIT:   if (ready) nxt = burst ? CH_BURST : CH_SINGLE;
            CH_SINGLE: if (xfer) nxt = CH_WAIT;
            CH_BURST:  if (xfer && beat == LAST) nxt = CH_WAIT;
        endcase
        if (!en) nxt = CH_OFF;
    end
endmodule

// File: rtl/dma_route.sv
module dma_route #(
    parameter int NCH   = 2,
    parameter int NFIFO = 3,
    parameter int DW    = 32,
    parameter int SELW  = 2
) (
    input  logic [NCH*SELW-1:0] sel,
    input  logic [NCH-1:0]      dir,
    input  logic [NCH-1:0]      xfer,
    input  logic                wide,
    input  logic [DW-1:0]       bus_wdata,
    input  logic [NFIFO-1:0]    fifo_full,
    input  logic [NFIFO-1:0]    fifo_empty,
    input  logic [NFIFO*DW-1:0] fifo_rdata,
    output logic [NCH-1:0]      ready,
    output logic [NFIFO-1:0]    fifo_push,
    output logic [NFIFO-1:0]    fifo_pop,
    output logic [DW-1:0]       fifo_wdata,
    output logic [DW-1:0]       bus_rdata
);
    localparam int HALF = DW / 2;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] w, input logic full_width);
        fit = full_width ? w : {{(DW-HALF){1'b0}}, w[HALF-1:0]};
    endfunction

    logic [DW-1:0] popped;

    always_comb begin
        ready     = '0;
        fifo_push = '0;
        fifo_pop  = '0;
        popped    = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int f = 0; f < NFIFO; f++) begin
                if (sel[c*SELW +: SELW] == SELW'(f)) begin
                    ready[c] = dir[c] ? !fifo_full[f] : !fifo_empty[f];
                    if (xfer[c] && dir[c])  fifo_push[f] = 1'b1;
                    if (xfer[c] && !dir[c]) begin
                        fifo_pop[f] = 1'b1;
                        popped      = popped | fifo_rdata[f*DW +: DW];
                    end
                end
            end
        end
        fifo_wdata = fit(bus_wdata, wide);
        bus_rdata  = fit(popped, wide);
    end
endmodule

// File: rtl/dma_port.sv
module dma_port
    import dma_port_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int NFIFO     = 3,
    parameter int DW        = 32,
    parameter int BURST_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ch_en,
    input  logic [2*NCH-1:0]      ch_sel,
    input  logic [NCH-1:0]        ch_dir,
    input  logic [NCH-1:0]        ch_burst,
    input  logic [2*NCH-1:0]      ch_qual,
    input  logic                  wide,
    input  logic [NCH-1:0]        dack,
    input  logic                  stb,
    input  logic [NCH-1:0]        dcs,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic [NCH-1:0]        dreq,
    input  logic [NFIFO-1:0]      fifo_full,
    input  logic [NFIFO-1:0]      fifo_empty,
    input  logic [NFIFO*DW-1:0]   fifo_rdata,
    output logic [NFIFO-1:0]      fifo_push,
    output logic [NFIFO-1:0]      fifo_pop,
    output logic [DW-1:0]         fifo_wdata,
    output logic                  cfg_err,
    output logic [NCH-1:0]        flow_err
);
    localparam int SELW = 2;

    logic [NCH-1:0] blocked, en_eff, raw, hit, xfer, ready;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SELW-1:0] s;
        logic clash, qok;
        assign s = ch_sel[c*SELW +: SELW];

        always_comb begin
            clash = 1'b0;
            for (int d = 0; d < c; d++)
                if (ch_en[d] && ch_sel[d*SELW +: SELW] == s) clash = 1'b1;
        end

        always_comb begin
            unique case (qual_e'(ch_qual[c*2 +: 2]))
                QUAL_STROBE: qok = stb;
                QUAL_FLYBY:  qok = 1'b1;
                QUAL_DCS:    qok = dcs[c];
                QUAL_NONE:   qok = 1'b0;
            endcase
        end

        assign blocked[c] = ch_en[c] && (s < SELW'(NFIFO)) && clash;
        assign en_eff[c]  = ch_en[c] && (s < SELW'(NFIFO)) && !clash;
        assign raw[c]     = dreq[c] && dack[c] && qok;

        dma_chan_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_eff[c]),
            .burst    (ch_burst[c]),
            .ready    (ready[c]),
            .hit      (hit[c]),
            .dreq     (dreq[c]),
            .xfer     (xfer[c]),
            .flow_err (flow_err[c])
        );
    end

    // lowest-numbered qualified acknowledge owns the bus
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            hit[c] = raw[c] && !taken;
            taken  = taken | raw[c];
        end
    end

    assign cfg_err = |blocked;

    dma_route #(.NCH(NCH), .NFIFO(NFIFO), .DW(DW), .SELW(SELW)) u_route (
        .sel        (ch_sel),
        .dir        (ch_dir),
        .xfer       (xfer),
        .wide       (wide),
        .bus_wdata  (bus_wdata),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .ready      (ready),
        .fifo_push  (fifo_push),
        .fifo_pop   (fifo_pop),
        .fifo_wdata (fifo_wdata),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: rtl/dma_port_chk.sv
module dma_port_chk #(
    parameter int NCH   = 2,
    parameter int NFIFO = 3,
    parameter int DW    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide,
    input logic [NCH-1:0]    dreq,
    input logic [NCH-1:0]    blocked,
    input logic [NCH-1:0]    flow_err,
    input logic [NFIFO-1:0]  fifo_full,
    input logic [NFIFO-1:0]  fifo_empty,
    input logic [NFIFO-1:0]  fifo_push,
    input logic [NFIFO-1:0]  fifo_pop,
    input logic [DW-1:0]     fifo_wdata,
    input logic [DW-1:0]     bus_rdata
);
    AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_push, fifo_pop})); // R10
    AST_NO_REQ_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|dreq) |-> !(|{fifo_push, fifo_pop})); // R10
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push & fifo_full) == '0); // R5
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop & fifo_empty) == '0); // R5
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (fifo_wdata[DW-1:DW/2] == '0 && bus_rdata[DW-1:DW/2] == '0)); // R9

    for (genvar c = 0; c < NCH; c++) begin : g_c
        AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            blocked[c] |=> !dreq[c]); // R7
        AST_FLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flow_err[c] |=> flow_err[c]); // R8
    end
endmodule

bind dma_port dma_port_chk #(.NCH(NCH), .NFIFO(NFIFO), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide       (wide),
    .dreq       (dreq),
    .blocked    (blocked),
    .flow_err   (flow_err),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .fifo_wdata (fifo_wdata),
    .bus_rdata  (bus_rdata)
);

// File: tb/tb_dma_port.sv
`timescale 1ns/1ps
module tb_dma_port;
    localparam int NCH = 2, NFIFO = 3, DW = 32, BL = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic [NCH-1:0] ch_en, ch_dir, ch_burst, dack, dcs;
    logic [2*NCH-1:0] ch_sel, ch_qual;
    logic wide, stb;
    logic [DW-1:0] bus_wdata, bus_rdata, fifo_wdata;
    logic [NCH-1:0] dreq, flow_err;
    logic [NFIFO-1:0] fifo_full, fifo_empty, fifo_push, fifo_pop;
    logic [NFIFO*DW-1:0] fifo_rdata;
    logic cfg_err;

    dma_port dut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_sel(ch_sel), .ch_dir(ch_dir),
        .ch_burst(ch_burst), .ch_qual(ch_qual), .wide(wide), .dack(dack), .stb(stb),
        .dcs(dcs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dreq(dreq),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata),
        .cfg_err(cfg_err), .flow_err(flow_err)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] rs = 32'h1234_5678;

    // reference model state: 0 off, 1 waiting, 2 single request, 3 burst request
    int ph[NCH];
    int cnt[NCH];
    bit ferr[NCH];

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] fitw(input logic [DW-1:0] w);
        return wide ? w : (w & 32'h0000_FFFF);
    endfunction

    task automatic model_cycle();
        bit e[NCH], rdy[NCH], hitq[NCH], xf[NCH];
        int sl[NCH];
        bit taken;
        logic [NFIFO-1:0] ep, eo;
        logic [DW-1:0] erd;
        logic [NCH-1:0] edr, efe;
        bit ecfg;
        ecfg = 0;
        for (int c = 0; c < NCH; c++) sl[c] = int'(ch_sel[c*2 +: 2]);
        for (int c = 0; c < NCH; c++) begin
            bit clash;
            clash = 0;
            for (int d = 0; d < c; d++) if (ch_en[d] && sl[d] == sl[c]) clash = 1;
            if (ch_en[c] && sl[c] < 3 && clash) ecfg = 1;
            e[c] = ch_en[c] && sl[c] < 3 && !clash;
            rdy[c] = 0;
            if (sl[c] < 3) rdy[c] = ch_dir[c] ? !fifo_full[sl[c]] : !fifo_empty[sl[c]];
        end
        taken = 0; ep = '0; eo = '0; erd = '0;
        for (int c = 0; c < NCH; c++) begin
            bit q, act;
            case (ch_qual[c*2 +: 2])
                2'd0: q = stb;
                2'd1: q = 1;
                2'd2: q = dcs[c];
                default: q = 0;
            endcase
            act = (ph[c] >= 2);
            hitq[c] = act && dack[c] && q && !taken;
            if (act && dack[c] && q) taken = 1;
            xf[c] = hitq[c] && rdy[c];
            edr[c] = act;
            if (xf[c]) begin
                if (ch_dir[c]) ep[sl[c]] = 1'b1;
                else begin
                    eo[sl[c]] = 1'b1;
                    erd = fitw(fifo_rdata[sl[c]*DW +: DW]);
                end
            end
            efe[c] = ferr[c];
        end
        chk("R3 R4 R7 dreq", {30'd0, dreq}, {30'd0, edr});
        chk("R2 R5 R6 R10 fifo_push", {29'd0, fifo_push}, {29'd0, ep});
        chk("R2 R5 R6 R10 fifo_pop", {29'd0, fifo_pop}, {29'd0, eo});
        chk("R5 R9 bus_rdata", bus_rdata, erd);
        chk("R9 fifo_wdata", fifo_wdata, fitw(bus_wdata));
        chk("R7 cfg_err", {31'd0, cfg_err}, {31'd0, ecfg});
        chk("R8 flow_err", {30'd0, flow_err}, {30'd0, efe});
        // advance to the state after the coming edge
        for (int c = 0; c < NCH; c++) begin
            if (hitq[c] && !rdy[c]) ferr[c] = 1;
            if (!e[c]) ph[c] = 0;
            else case (ph[c])
                0: ph[c] = 1;
                1: begin
                    cnt[c] = 0;
                    if (rdy[c]) ph[c] = ch_burst[c] ? 3 : 2;
                end
                2: if (xf[c]) ph[c] = 1;
                default: if (xf[c]) begin
                    if (cnt[c] == BL - 1) ph[c] = 1;
                    else cnt[c]++;
                end
            endcase
        end
    endtask

    task automatic cyc();
        #2;
        model_cycle();
        @(negedge clk);
    endtask

    task automatic cfg(input int c, input bit en, input int sel, input bit dir,
                       input bit bst, input int q);
        ch_en[c] = en;
        ch_sel[c*2 +: 2] = 2'(sel);
        ch_dir[c] = dir;
        ch_burst[c] = bst;
        ch_qual[c*2 +: 2] = 2'(q);
    endtask

    task automatic churn_data();
        bus_wdata = rnd();
        fifo_rdata = {rnd(), rnd(), rnd()};
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; ch_en = '0; ch_sel = '0; ch_dir = '0; ch_burst = '0; ch_qual = '0;
        wide = 1; dack = '0; stb = 0; dcs = '0; bus_wdata = '0;
        fifo_full = '0; fifo_empty = '1; fifo_rdata = '0;
        for (int c = 0; c < NCH; c++) begin ph[c] = 0; cnt[c] = 0; ferr[c] = 0; end
        repeat (3) @(negedge clk);
        // R1: values held during reset
        chk("R1 dreq in reset", {30'd0, dreq}, 32'd0);
        chk("R1 push/pop in reset", {26'd0, fifo_push, fifo_pop}, 32'd0);
        chk("R1 errors in reset", {29'd0, cfg_err, flow_err}, 32'd0);
        chk("R1 bus_rdata in reset", bus_rdata, 32'd0);
        rst_n = 1;

        // R10: acknowledges while idle; R3 single fly-by writes into pixel FIFO
        dack = 2'b01;
        repeat (2) begin churn_data(); cyc(); end
        cfg(0, 1, 0, 1, 0, 1);
        repeat (12) begin churn_data(); cyc(); end
        // R4 R6: burst reads from code FIFO, strobe qualifier toggling
        fifo_empty = 3'b101;
        cfg(0, 1, 1, 0, 1, 0);
        for (int i = 0; i < 20; i++) begin stb = i[0]; churn_data(); cyc(); end
        // R6 R9: channel 1 dedicated select writes to attribute, narrow width
        wide = 0; stb = 0; dack = 2'b10;
        cfg(0, 0, 1, 0, 0, 0);
        cfg(1, 1, 2, 1, 0, 2);
        for (int i = 0; i < 14; i++) begin dcs = {i[1], 1'b0}; churn_data(); cyc(); end
        // R10: both channels acknowledge together
        wide = 1; dack = 2'b11; dcs = 2'b11;
        cfg(0, 1, 0, 1, 1, 1);
        cfg(1, 1, 1, 0, 1, 1);
        repeat (14) begin churn_data(); cyc(); end
        // R7: both channels on the code FIFO
        cfg(0, 1, 1, 0, 0, 1);
        repeat (6) begin churn_data(); cyc(); end
        // R2: select code 3 and R6 qualifier code 3
        cfg(0, 1, 3, 1, 0, 1);
        cfg(1, 1, 0, 1, 0, 3);
        repeat (6) begin churn_data(); cyc(); end
        // R8: request up, then FIFO goes full / empty while acknowledged
        dack = 2'b00;
        cfg(0, 1, 0, 1, 1, 1);
        cfg(1, 1, 2, 0, 0, 1);
        fifo_full = 3'b000; fifo_empty = 3'b000;
        repeat (3) begin churn_data(); cyc(); end
        fifo_full = 3'b001; fifo_empty = 3'b100; dack = 2'b11;
        repeat (4) begin churn_data(); cyc(); end
        fifo_full = 3'b000; fifo_empty = 3'b000;
        repeat (6) begin churn_data(); cyc(); end

        // mixed phase: all inputs vary, configuration shifts every 40 cycles
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = rnd();
            if (i % 40 == 0) begin
                logic [31:0] k;
                k = rnd();
                ch_en = k[1:0] | 2'(k[2]);
                ch_sel = k[7:4]; ch_dir = k[9:8]; ch_burst = k[11:10];
                ch_qual = k[15:12]; wide = k[16];
            end
            dack = r[1:0]; stb = r[2]; dcs = r[4:3];
            fifo_full = r[7:5] & r[10:8];
            fifo_empty = r[13:11] & r[16:14];
            if (r[31:28] == 4'hF) rst_n = 0;
            churn_data();
            if (!rst_n) begin
                @(negedge clk);
                rst_n = 1;
                for (int c = 0; c < NCH; c++) begin ph[c] = 0; cnt[c] = 0; ferr[c] = 0; end
            end else cyc();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule